// File: doc/BRIEF.md
# Multi-channel frequency and elapsed-time meter

This block measures clocks against a reference. A simple register bus (address, write enable, write data, combinational read data) sets each channel's mode, the reference window length and the clock selection. The same bus starts and stops a run and reads back one result count per channel. A reference timer runs in the reference clock domain. It opens a counting window that lasts a programmed number of reference cycles. A window length of zero leaves the window open until software stops the run.

In frequency mode a channel counts edges of its own input clock while the window is open. The result, divided by the window length, gives the input frequency relative to the reference. In time mode a channel instead counts cycles of the reference clock, or of a faster alternate clock, so the result is elapsed time. Every crossing between domains is a level handshake through two-flop synchronisers. Arming, gating and acknowledgement move this way. Each final count is frozen in its own domain and copied into a bus-side result register only after every active channel has acknowledged the end of the run. A clock-monitor output can pass any one raw channel clock to a pin.

Top module: `freq_meter`

## Requirements
- R1: After reset the control word (0x00) reads 0, clock select (0x04) reads 0, the window length (0x08) reads REF_RESET (default 10000), the mode word (0x0C) reads 0 and every count word reads 0.
- R2: The mode word holds a 2-bit field per channel at bits 2i+1:2i, coded 00 disabled, 01 frequency, 11 time. A write of the reserved code 10 stores 00. Fields of channels at or above NCH always read 00 and cannot be enabled.
- R3: Writing 1 to bit 0 of the control word while idle starts a run. Bit 0 reads 1 while the run is active and returns to 0 by itself when the run completes.
- R4: In frequency mode a channel's result equals the number of its input clock cycles that fall in a window of N reference cycles (N = window length), to within 3 counts.
- R5: In time mode a channel counts reference clock cycles, or alternate clock cycles when bit 1 of clock select is 1, for as long as the window is open. With a window length of 0 the run stays active until a stop.
- R6: Writing 1 to bit 1 of the control word during a run ends it early. The busy bit clears only after every active channel has frozen its count, and bit 1 always reads 0.
- R7: Channel i's result is read at byte address 0x10 + 4*i as a CNT_W-bit count with all higher bits zero. A count saturates at all ones instead of wrapping.
- R8: A new run clears the counters of enabled channels. A channel disabled for that run keeps its previous result.
- R9: While a run is active, writes to the mode word, window length and clock select are ignored. Reserved bits read as 0: window length bits 31:REF_W, and clock select bits 31:8 and 3:2.
- R10: Bit 0 of clock select chooses the reference clock: 0 selects ref_clk_a and 1 selects ref_clk_b.
- R11: mon_clk follows the raw chan_clk selected by clock select bits 6:4 when bit 7 is 1. It is held low when bit 7 is 0 or when the selected channel is not implemented.
- R12: Result words change only at the end of a run. While a run is active they keep the values of the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe for one bus cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ref_clk_a | input | 1 | Reference clock, first choice |
| ref_clk_b | input | 1 | Reference clock, second choice |
| alt_clk | input | 1 | Fast alternate clock for time mode |
| chan_clk | input | NCH | Per-channel measured clocks |
| mon_clk | output | 1 | Clock monitor output |

## Verification
The bench builds the block with NCH=6, so writes that try to enable channels 6 and 7 can be seen to fail, and a monitor selection of an absent channel can be checked. It sets CNT_W=12, which makes the all-ones saturation point (4095) reachable in a run of a few thousand reference cycles, while REF_W stays at 24 so the default window length of 10000 and the full-width reserved-bit readback are both exercised. Channel clocks of six different periods, two reference periods and a faster alternate clock bring the frequency ratio, reference selection and time mode on both clock sources within reach.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_FREQ = 2'b01,
        MODE_RSVD = 2'b10,
        MODE_TIME = 2'b11
    } chan_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RUN,
        ST_DRAIN,
        ST_CAPTURE
    } run_state_e;

    typedef struct packed {
        logic       mon_en;
        logic [2:0] mon_sel;
        logic       alt_sel;
        logic       ref_sel;
    } clk_cfg_t;

    localparam int MAX_CHANNELS = 8;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_CKSEL = 8'h04;
    localparam logic [7:0] OFS_WIN   = 8'h08;
    localparam logic [7:0] OFS_MODE  = 8'h0C;
    localparam logic [7:0] OFS_CNT0  = 8'h10;

    function automatic chan_mode_e mode_from_bits(input logic [1:0] b);
        case (b)
            2'b01:   return MODE_FREQ;
            2'b11:   return MODE_TIME;
            default: return MODE_OFF;
        endcase
    endfunction

    function automatic logic mode_active(input chan_mode_e m);
        return (m == MODE_FREQ) || (m == MODE_TIME);
    endfunction

    function automatic logic [31:0] cksel_word(input clk_cfg_t c);
        return {24'h0, c.mon_en, c.mon_sel, 2'b00, c.alt_sel, c.ref_sel};
    endfunction

    function automatic clk_cfg_t cksel_from_word(input logic [31:0] w);
        clk_cfg_t c;
        c.ref_sel = w[0];
        c.alt_sel = w[1];
        c.mon_sel = w[6:4];
        c.mon_en  = w[7];
        return c;
    endfunction

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/fm_ref_timer.sv
module fm_ref_timer #(
    parameter int REF_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [REF_W-1:0] limit,
    output logic             gate,
    output logic             done,
    output logic             ack
);

    logic             arm_s;
    logic [REF_W-1:0] elapsed;

    fm_sync #(.WIDTH(1)) u_arm_sync (
        .clk (clk),
        .rst (rst),
        .d   (arm),
        .q   (arm_s)
    );

    always_ff @(posedge clk) begin
        if (rst || !arm_s) begin
            elapsed <= '0;
            gate    <= 1'b0;
            done    <= 1'b0;
        end else if (!gate && !done) begin
            gate    <= 1'b1;
            elapsed <= '0;
        end else if (gate) begin
            elapsed <= elapsed + 1'b1;
            if (limit != '0 && elapsed == limit - 1'b1) begin
                gate <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= arm_s;
    end

    // R4: the window closes only after exactly limit reference cycles
    assert_window_len_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (elapsed == limit && limit != '0));

    // R4: a closed window never reopens within the same run
    assert_window_closed_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> !gate);

    // R5: with a zero limit the window never completes by itself
    assert_endless_R5: assert property (@(posedge clk) disable iff (rst)
        (limit == '0) |=> !$rose(done));

endmodule

// File: rtl/fm_channel.sv
module fm_channel #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             gate,
    input  logic             enable,
    output logic [CNT_W-1:0] count,
    output logic             ack
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic arm_s, gate_s, arm_d;
    logic start;

    fm_sync #(.WIDTH(2)) u_in_sync (
        .clk (clk),
        .rst (rst),
        .d   ({arm, gate}),
        .q   ({arm_s, gate_s})
    );

    assign start = arm_s && !arm_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_d <= 1'b0;
            ack   <= 1'b0;
            count <= '0;
        end else begin
            arm_d <= arm_s;
            ack   <= arm_s;
            if (start && enable)
                count <= '0;
            else if (arm_s && gate_s && enable && count != CNT_MAX)
                count <= count + 1'b1;
        end
    end

    // R7: a saturated count stays saturated until a new run clears it
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX && !start) |=> (count == CNT_MAX));

    // R12: once disarmed the count is frozen for the capture
    assert_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        !arm_s |=> $stable(count));

endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import fm_pkg::*;
#(
    parameter int          NCH       = 8,
    parameter int          CNT_W     = 24,
    parameter int          REF_W     = 24,
    parameter int unsigned REF_RESET = 10000,
    parameter int          ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ref_clk_a,
    input  logic              ref_clk_b,
    input  logic              alt_clk,
    input  logic [NCH-1:0]    chan_clk,
    output logic              mon_clk
);

    localparam int MAXCH = MAX_CHANNELS;

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CKSEL = ADDR_W'(OFS_CKSEL);
    localparam logic [ADDR_W-1:0] A_WIN   = ADDR_W'(OFS_WIN);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);

    // bus-domain state
    run_state_e       state;
    logic             arm;
    logic             stop_pend;
    logic             busy;
    clk_cfg_t         cfg;
    logic [REF_W-1:0] ref_limit;
    chan_mode_e       mode_q  [NCH];
    logic [CNT_W-1:0] results [NCH];

    // cross-domain signals
    logic             ref_clk, time_clk, ref_rst;
    logic             ref_gate, ref_done, ref_ack;
    logic             ref_done_s, ref_ack_s;
    logic [NCH-1:0]   ch_ack, ch_ack_s, en_mask;
    logic [CNT_W-1:0] ch_cnt  [NCH];

    // readback helpers
    logic [2*MAXCH-1:0] mode_rd;
    logic [31:0]        cnt_rd  [MAXCH];
    logic [MAXCH-1:0]   mon_src;
    logic [2*NCH-1:0]   mode_flat;
    logic [CNT_W*NCH-1:0] results_flat;

    logic wr_ctrl, wr_cfg_ok, all_up, all_down;
    logic unused_wdata;

    assign busy         = (state != ST_IDLE);
    assign wr_ctrl      = bus_we && (bus_addr == A_CTRL);
    assign wr_cfg_ok    = bus_we && !busy;
    assign all_up       = ref_ack_s && ((ch_ack_s & en_mask) == en_mask);
    assign all_down     = !ref_ack_s && ((ch_ack_s & en_mask) == '0);
    assign unused_wdata = ^bus_wdata;

    // ------------------------------------------------------------------
    // per-channel structure: mode decode, clock selection, counter
    // ------------------------------------------------------------------
    assign ref_clk  = cfg.ref_sel ? ref_clk_b : ref_clk_a;
    assign time_clk = cfg.alt_sel ? alt_clk : ref_clk;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic cclk, crst;

        assign en_mask[i] = mode_active(mode_q[i]);
        assign cclk       = (mode_q[i] == MODE_TIME) ? time_clk : chan_clk[i];
        assign mode_flat[2*i +: 2]         = mode_q[i];
        assign results_flat[CNT_W*i +: CNT_W] = results[i];

        fm_sync #(.WIDTH(1)) u_rst_sync (
            .clk (cclk),
            .rst (1'b0),
            .d   (rst),
            .q   (crst)
        );

        fm_channel #(.CNT_W(CNT_W)) u_counter (
            .clk    (cclk),
            .rst    (crst),
            .arm    (arm),
            .gate   (ref_gate),
            .enable (en_mask[i]),
            .count  (ch_cnt[i]),
            .ack    (ch_ack[i])
        );
    end

    for (genvar i = 0; i < MAXCH; i++) begin : g_view
        if (i < NCH) begin : g_impl
            assign mode_rd[2*i +: 2] = mode_q[i];
            assign cnt_rd[i]         = 32'(results[i]);
            assign mon_src[i]        = chan_clk[i];
        end else begin : g_absent
            assign mode_rd[2*i +: 2] = 2'b00;
            assign cnt_rd[i]         = 32'h0;
            assign mon_src[i]        = 1'b0;
        end
    end

    assign mon_clk = cfg.mon_en & mon_src[cfg.mon_sel];

    // ------------------------------------------------------------------
    // reference domain
    // ------------------------------------------------------------------
    fm_sync #(.WIDTH(1)) u_ref_rst_sync (
        .clk (ref_clk),
        .rst (1'b0),
        .d   (rst),
        .q   (ref_rst)
    );

    fm_ref_timer #(.REF_W(REF_W)) u_ref_timer (
        .clk   (ref_clk),
        .rst   (ref_rst),
        .arm   (arm),
        .limit (ref_limit),
        .gate  (ref_gate),
        .done  (ref_done),
        .ack   (ref_ack)
    );

    fm_sync #(.WIDTH(NCH + 2)) u_back_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ref_done, ref_ack, ch_ack}),
        .q   ({ref_done_s, ref_ack_s, ch_ack_s})
    );

    // ------------------------------------------------------------------
    // bus-domain registers and run sequencer
    // ------------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            arm       <= 1'b0;
            stop_pend <= 1'b0;
            cfg       <= '0;
            ref_limit <= REF_W'(REF_RESET);
            for (int i = 0; i < NCH; i++) begin
                mode_q[i]  <= MODE_OFF;
                results[i] <= '0;
            end
        end else begin
            if (wr_cfg_ok && bus_addr == A_CKSEL)
                cfg <= cksel_from_word(bus_wdata);
            if (wr_cfg_ok && bus_addr == A_WIN)
                ref_limit <= bus_wdata[REF_W-1:0];
            if (wr_cfg_ok && bus_addr == A_MODE)
                for (int i = 0; i < NCH; i++)
                    mode_q[i] <= mode_from_bits(bus_wdata[2*i +: 2]);

            if (wr_ctrl && bus_wdata[1] && busy)
                stop_pend <= 1'b1;

            case (state)
                ST_IDLE: begin
                    stop_pend <= 1'b0;
                    if (wr_ctrl && bus_wdata[0]) begin
                        arm   <= 1'b1;
                        state <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (all_up) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (stop_pend || ref_done_s) begin
                        arm   <= 1'b0;
                        state <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (all_down) state <= ST_CAPTURE;
                end
                ST_CAPTURE: begin
                    for (int i = 0; i < NCH; i++)
                        if (en_mask[i]) results[i] <= ch_cnt[i];
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_rdata = 32'h0;
        if (bus_addr == A_CTRL)
            bus_rdata[0] = busy;
        else if (bus_addr == A_CKSEL)
            bus_rdata = cksel_word(cfg);
        else if (bus_addr == A_WIN)
            bus_rdata = 32'(ref_limit);
        else if (bus_addr == A_MODE)
            bus_rdata = {16'h0, mode_rd};
        for (int i = 0; i < MAXCH; i++)
            if (bus_addr == ADDR_W'(32'(OFS_CNT0) + 4 * i))
                bus_rdata = cnt_rd[i];
    end

    // ------------------------------------------------------------------
    // assertions
    // ------------------------------------------------------------------
    // R3: a start request from idle makes the block busy on the next cycle
    assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_ctrl && bus_wdata[0]) |=> busy);

    // R9: configuration is frozen while a run is active
    assert_cfg_lock_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(mode_flat) && $stable(ref_limit) && $stable(cfg)));

    // R12: results move only in the capture step
    assert_results_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (state != ST_CAPTURE) |=> $stable(results_flat));

    // R6: capture happens only after every active domain has acknowledged disarm
    assert_drained_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAPTURE) |-> (!ref_ack_s && (ch_ack_s & en_mask) == '0));

    // R6: a pending stop is honoured on the cycle the run state is reached
    assert_stop_honoured_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && stop_pend) |=> (state == ST_DRAIN && !arm));

endmodule

// File: tb/freq_meter_bench.sv
`timescale 1ns/100ps
module freq_meter_bench;

    localparam int NCH   = 6;
    localparam int CNT_W = 12;
    localparam int REF_W = 24;

    localparam int REF_A_P = 10;
    localparam int REF_B_P = 20;
    localparam int ALT_P   = 4;
    localparam int CH_P [NCH] = '{10, 6, 20, 8, 40, 12};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_clk_a = 1'b0, ref_clk_b = 1'b0, alt_clk = 1'b0;
    logic [NCH-1:0] chan_clk = '0;
    logic        mon_clk;

    int n_chk  = 0;
    int n_fail = 0;

    // behavioural model of the configuration state
    bit          m_busy  = 0;
    logic [31:0] m_mode  = 32'h0;
    logic [31:0] m_cksel = 32'h0;
    logic [31:0] m_win   = 32'd10000;

    always #2 clk = ~clk;
    always #(REF_A_P/2) ref_clk_a = ~ref_clk_a;
    always #(REF_B_P/2) ref_clk_b = ~ref_clk_b;
    always #(ALT_P/2)   alt_clk   = ~alt_clk;
    for (genvar i = 0; i < NCH; i++) begin : g_clk
        always #(CH_P[i]/2) chan_clk[i] = ~chan_clk[i];
    end

    freq_meter #(.NCH(NCH), .CNT_W(CNT_W), .REF_W(REF_W)) u_freq_meter (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_clk_a (ref_clk_a),
        .ref_clk_b (ref_clk_b),
        .alt_clk   (alt_clk),
        .chan_clk  (chan_clk),
        .mon_clk   (mon_clk)
    );

    function automatic logic [31:0] model_mode(input logic [31:0] w);
        logic [31:0] r = 32'h0;
        for (int i = 0; i < NCH; i++) begin
            if (w[2*i +: 2] == 2'b01 || w[2*i +: 2] == 2'b11)
                r[2*i +: 2] = w[2*i +: 2];
        end
        return r;
    endfunction

    function automatic logic model_mon();
        int sel = int'(m_cksel[6:4]);
        if (!m_cksel[7] || sel >= NCH) return 1'b0;
        return chan_clk[sel];
    endfunction

    task automatic check(input bit ok, input string req, input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_near(input string req, input longint got, input longint window_ns,
                              input longint period_ns, input longint tol);
        longint diff = got * period_ns - window_ns;
        if (diff < 0) diff = -diff;
        check(diff <= tol * period_ns, req, got, window_ns / period_ns);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (!m_busy) begin
            if (a == 6'h04) m_cksel = d & 32'h0000_00F3;
            if (a == 6'h08) m_win   = d & 32'h00FF_FFFF;
            if (a == 6'h0C) m_mode  = model_mode(d);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int cycles);
        logic [31:0] v;
        cycles = 0;
        do begin
            rd(6'h00, v);
            cycles++;
        end while (v[0] && cycles < 40000);
        m_busy = 0;
    endtask

    task automatic start_run();
        wr(6'h00, 32'h1);
        m_busy = 1;
    endtask

    // per-clock comparison of the monitor output against the model (R11)
    always @(negedge clk) begin
        if (!rst) begin
            #0.5;
            check(mon_clk == model_mon(), "R11 monitor", longint'(mon_clk), longint'(model_mon()));
        end
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, saved;
        int cyc;
        longint t0, t1;

        repeat (40) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        // R1 reset state
        rd(6'h00, v); check(v == 32'h0, "R1 control", v, 0);
        rd(6'h04, v); check(v == 32'h0, "R1 clock select", v, 0);
        rd(6'h08, v); check(v == 32'd10000, "R1 window", v, 10000);
        rd(6'h0C, v); check(v == 32'h0, "R1 mode", v, 0);
        rd(6'h10, v); check(v == 32'h0, "R1 count0", v, 0);
        rd(6'h24, v); check(v == 32'h0, "R1 count5", v, 0);
        rd(6'h28, v); check(v == 32'h0, "R1 count6 absent", v, 0);

        // R2 mode coding and absent channels
        wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, v); check(v == m_mode, "R2 all time", v, m_mode);
        check(m_mode == 32'h0000_0FFF, "R2 model", m_mode, 32'h0FFF);
        wr(6'h0C, 32'h0000_AAAA); rd(6'h0C, v); check(v == 32'h0, "R2 reserved code", v, 0);
        wr(6'h0C, 32'h0000_0E1D); rd(6'h0C, v); check(v == 32'h0000_0C1D, "R2 mixed", v, 32'h0C1D);

        // R9 reserved bits
        wr(6'h08, 32'hFFFF_FFFF); rd(6'h08, v); check(v == 32'h00FF_FFFF, "R9 window reserved", v, 32'hFFFFFF);
        wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); check(v == 32'h0000_00F3, "R9 cksel reserved", v, 32'hF3);
        wr(6'h04, 32'h0);

        // run A: all channels in frequency mode
        wr(6'h08, 32'd200);
        wr(6'h0C, 32'h0000_0555);
        start_run();
        rd(6'h00, v); check(v == 32'h1, "R3 busy during run", v, 1);
        rd(6'h10, v); check(v == 32'h0, "R12 result held during run", v, 0);
        wait_idle(cyc);
        rd(6'h00, v); check(v == 32'h0, "R3 start self-clears", v, 0);
        for (int i = 0; i < NCH; i++) begin
            rd(6'(16 + 4 * i), v);
            check_near("R4 frequency count", longint'(v), 200 * REF_A_P, CH_P[i], 3);
            check(v[31:CNT_W] == '0, "R7 upper bits zero", longint'(v[31:CNT_W]), 0);
        end

        // run B: lock while busy, then stop early
        wr(6'h08, 32'd2000);
        start_run();
        repeat (50) @(negedge clk);
        wr(6'h0C, 32'h0);
        wr(6'h08, 32'd5);
        wr(6'h04, 32'h80);
        rd(6'h0C, v); check(v == 32'h555, "R9 mode locked", v, 32'h555);
        rd(6'h08, v); check(v == 32'd2000, "R9 window locked", v, 2000);
        rd(6'h04, v); check(v == 32'h0, "R9 cksel locked", v, 0);
        rd(6'h00, v); check(v == 32'h1, "R6 stop bit reads zero", v, 1);
        wr(6'h00, 32'h2);
        wait_idle(cyc);
        check(cyc < 100, "R6 stop completes", cyc, 100);
        rd(6'h10, v); check(v > 0 && v < 100, "R6 partial count", v, 30);

        // run C: second reference clock, channel 1 disabled keeps its value
        rd(6'h14, saved);
        wr(6'h04, 32'h1);
        wr(6'h0C, 32'h001);
        wr(6'h08, 32'd100);
        start_run();
        wait_idle(cyc);
        rd(6'h10, v); check_near("R10 reference b", longint'(v), 100 * REF_B_P, CH_P[0], 3);
        rd(6'h14, v); check(v == saved, "R8 disabled retains", v, saved);

        // run D: time mode on reference, endless window, stopped
        wr(6'h04, 32'h0);
        wr(6'h0C, 32'h030);
        wr(6'h08, 32'd0);
        start_run();
        t0 = $time;
        repeat (400) @(negedge clk);
        rd(6'h00, v); check(v == 32'h1, "R5 endless window still busy", v, 1);
        wr(6'h00, 32'h2);
        t1 = $time;
        wait_idle(cyc);
        rd(6'h18, v); check_near("R5 time on reference", longint'(v), t1 - t0, REF_A_P, 8);

        // run E: time mode on alternate clock, bounded window
        wr(6'h04, 32'h2);
        wr(6'h08, 32'd300);
        start_run();
        wait_idle(cyc);
        rd(6'h18, v); check_near("R5 time on alternate", longint'(v), 300 * REF_A_P, ALT_P, 3);

        // run F: saturation
        wr(6'h04, 32'h0);
        wr(6'h0C, 32'h004);
        wr(6'h08, 32'd3000);
        start_run();
        wait_idle(cyc);
        rd(6'h14, v); check(v == 32'd4095, "R7 saturates", v, 4095);

        // run G: cleared at the start of a new run
        wr(6'h08, 32'd60);
        start_run();
        wait_idle(cyc);
        rd(6'h14, v); check_near("R8 cleared on start", longint'(v), 60 * REF_A_P, CH_P[1], 3);

        // monitor selections
        begin
            int highs;
            wr(6'h04, 32'hB0);
            repeat (40) @(negedge clk);
            wr(6'h04, 32'hF0);
            highs = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk); #0.5;
                if (mon_clk) highs++;
            end
            check(highs == 0, "R11 absent channel low", highs, 0);
            wr(6'h04, 32'h10);
            highs = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk); #0.5;
                if (mon_clk) highs++;
            end
            check(highs == 0, "R11 disabled low", highs, 0);
            wr(6'h04, 32'h90);
            highs = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk); #0.5;
                if (mon_clk) highs++;
            end
            check(highs > 0, "R11 enabled toggles", highs, 20);
        end

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule